// File: doc/BRIEF.md
# Multi-Channel Countdown Timer Unit

This block is a memory-mapped timer peripheral on a simple single-cycle register bus. It holds three down-counting channels: channels 0 and 1 are 16 bits wide and channel 2 is 32 bits wide. It also holds a 40-bit free-running up-counter that raises no interrupt. Each down-counter has a reload register, a live count, a control word and a clear register. When a channel underflows it either reloads itself from its reload register or wraps to all ones, and it latches an interrupt flag that stays set until software clears it.

Counting is paced by single-cycle strobes from outside the block. A down-counter advances on the main strobe or on a slower alternate strobe, chosen by its control word. The up-counter has a strobe of its own. Software sets a channel up in three writes: first the control word with the enable bit clear, then the reload value, then the control word with the enable bit set. Reads return data in the same cycle as the address is presented.

Top module: `cdt_unit`

## Requirements
- R1: Address map (byte addresses). The channel banks start at 0x00, 0x20 and 0x80. Within a bank, the reload register is at +0x0, the live count at +0x4, the control word at +0x8 and the clear register at +0xC. The up-counter's low word is at 0x60 and its high word at 0x64. The clear register and any unmapped address read as zero.
- R2: A write to a reload register sets the reload value and the live count in the same clock edge. A count read returns the live count with all bits above the channel's width at zero.
- R3: The control word holds enable in bit 7 and tick select in bit 3. While enable is 1, the count drops by one on each selected strobe: the main strobe when select is 1, the alternate strobe when select is 0. The other strobe has no effect. While enable is 0, the count holds.
- R4: When an enabled channel with a count of zero sees a selected strobe, it underflows. With bit 6 of the control word at 1 (periodic), the count reloads from the reload register. With bit 6 at 0, the count wraps to the all-ones value of its width.
- R5: An underflow sets the channel's irq bit one cycle later. The bit stays set until the clear register is written, whatever data is written. If a clear and an underflow fall in the same cycle, the bit stays set.
- R6: The up-counter advances by one on each tick_fr strobe while bit 8 of its high word is 1, and holds while that bit is 0. Writes to the low word have no effect.
- R7: The high word reads the counter's bits 39:32 in bits 7:0 and the enable in bit 8. The low word reads bits 31:0.
- R8: A synchronous reset clears every count, reload value, control word, irq bit, the up-counter and its enable.
- R9: A control word reads back bits 7, 6 and 3 as written. Every other bit reads as zero.
- R10: A reload write takes priority over a strobe in the same cycle. The written value appears, and no underflow is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tick_main | input | 1 | Main pacing strobe for the down-counters |
| tick_alt | input | 1 | Alternate slow pacing strobe for the down-counters |
| tick_fr | input | 1 | Pacing strobe for the up-counter |
| irq | output | 3 | Latched underflow flags, one per down-counter |

## Verification
Reads are combinational, so bus_rdata is valid in the same cycle as the address. A write or strobe presented before a rising edge shows up in the counts and registers right after that edge. The irq bit for an underflow also appears right after the edge that takes the underflow. The bench drives every input at the falling edge and applies it to a bench-side model in the same step. It compares reads and irq one nanosecond after the following falling edge, so each expected value matches a design that is exactly one register deep. Directed sequences also pin the hand-computed counts at reload, wrap and same-cycle clear.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam logic [7:0] OFS_RELOAD = 8'h00;
  localparam logic [7:0] OFS_COUNT  = 8'h04;
  localparam logic [7:0] OFS_CTRL   = 8'h08;
  localparam logic [7:0] OFS_CLEAR  = 8'h0C;
  localparam logic [7:0] FR_LO_ADDR = 8'h60;
  localparam logic [7:0] FR_HI_ADDR = 8'h64;

  localparam int CB_EN  = 7;
  localparam int CB_PER = 6;
  localparam int CB_SEL = 3;
  localparam int FR_EN_BIT = 8;

  typedef struct packed {
    logic en;
    logic per;
    logic sel;
  } ctrl_t;

  function automatic logic [7:0] bank_base(input int idx);
    case (idx)
      0:       return 8'h00;
      1:       return 8'h20;
      default: return 8'h80;
    endcase
  endfunction

  function automatic logic [31:0] ctrl_word(input ctrl_t c);
    logic [31:0] w;
    w = '0;
    w[CB_EN]  = c.en;
    w[CB_PER] = c.per;
    w[CB_SEL] = c.sel;
    return w;
  endfunction
endpackage

// File: rtl/cdt_down_chan.sv
module cdt_down_chan
  import cdt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_main,
  input  logic         tick_alt,
  input  logic         wr_reload,
  input  logic         wr_ctrl,
  input  logic         wr_clear,
  input  logic [W-1:0] reload_data,
  input  ctrl_t        ctrl_data,
  output logic [W-1:0] count_q,
  output logic [W-1:0] reload_q,
  output ctrl_t        ctrl_q,
  output logic         irq_q,
  output logic         uf_evt
);
  logic tick_sel;
  logic step;

  function automatic logic [W-1:0] next_count(input logic [W-1:0] cur,
                                              input logic [W-1:0] rel,
                                              input logic per);
    if (cur == '0) return per ? rel : '1;
    return cur - 1'b1;
  endfunction

  assign tick_sel = ctrl_q.sel ? tick_main : tick_alt;
  assign step     = ctrl_q.en && tick_sel && !wr_reload;
  assign uf_evt   = step && (count_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q  <= '0;
      reload_q <= '0;
      ctrl_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (wr_reload) begin
        count_q  <= reload_data;
        reload_q <= reload_data;
      end else if (step) begin
        count_q <= next_count(count_q, reload_q, ctrl_q.per);
      end
      if (wr_ctrl) ctrl_q <= ctrl_data;
      if (uf_evt) irq_q <= 1'b1;
      else if (wr_clear) irq_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cdt_free_ctr.sv
module cdt_free_ctr #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         wr_en_reg,
  input  logic         en_data,
  output logic [W-1:0] cnt_q,
  output logic         en_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      if (en_q && tick) cnt_q <= cnt_q + 1'b1;
      if (wr_en_reg) en_q <= en_data;
    end
  end
endmodule

// File: rtl/cdt_unit.sv
module cdt_unit
  import cdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NARROW_W = 16,
  parameter int WIDE_W = 32,
  parameter int FR_W = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_main,
  input  logic              tick_alt,
  input  logic              tick_fr,
  output logic [2:0]        irq
);
  localparam int NCH = 3;
  localparam int FR_HI_W = FR_W - DATA_W;

  logic [DATA_W-1:0] cnt_ext [NCH];
  logic [DATA_W-1:0] rel_ext [NCH];
  logic [DATA_W-1:0] ctl_ext [NCH];
  logic [NCH-1:0]    uf_evt;
  logic [NCH-1:0]    clr_evt;
  ctrl_t             wr_ctrl_val;
  logic [FR_W-1:0]   fr_cnt;
  logic              fr_en;
  logic [DATA_W-1:0] fr_hi_word;

  assign wr_ctrl_val = '{en: bus_wdata[CB_EN], per: bus_wdata[CB_PER], sel: bus_wdata[CB_SEL]};

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    localparam int W = (g == NCH - 1) ? WIDE_W : NARROW_W;
    localparam logic [7:0] BASE = bank_base(g);
    logic [W-1:0] count_w;
    logic [W-1:0] reload_w;
    ctrl_t        ctrl_w;
    logic         irq_w;
    logic         wr_rel;
    logic         wr_ctl;

    assign wr_rel     = bus_wr && (bus_addr == ADDR_W'(BASE + OFS_RELOAD));
    assign wr_ctl     = bus_wr && (bus_addr == ADDR_W'(BASE + OFS_CTRL));
    assign clr_evt[g] = bus_wr && (bus_addr == ADDR_W'(BASE + OFS_CLEAR));

    cdt_down_chan #(.W(W)) u_chan (
      .clk(clk),
      .rst(rst),
      .tick_main(tick_main),
      .tick_alt(tick_alt),
      .wr_reload(wr_rel),
      .wr_ctrl(wr_ctl),
      .wr_clear(clr_evt[g]),
      .reload_data(bus_wdata[W-1:0]),
      .ctrl_data(wr_ctrl_val),
      .count_q(count_w),
      .reload_q(reload_w),
      .ctrl_q(ctrl_w),
      .irq_q(irq_w),
      .uf_evt(uf_evt[g])
    );

    assign cnt_ext[g] = DATA_W'(count_w);
    assign rel_ext[g] = DATA_W'(reload_w);
    assign ctl_ext[g] = DATA_W'(ctrl_word(ctrl_w));
    assign irq[g]     = irq_w;
  end

  cdt_free_ctr #(.W(FR_W)) u_free (
    .clk(clk),
    .rst(rst),
    .tick(tick_fr),
    .wr_en_reg(bus_wr && (bus_addr == ADDR_W'(FR_HI_ADDR))),
    .en_data(bus_wdata[FR_EN_BIT]),
    .cnt_q(fr_cnt),
    .en_q(fr_en)
  );

  always_comb begin
    fr_hi_word = '0;
    fr_hi_word[FR_HI_W-1:0] = fr_cnt[FR_W-1:DATA_W];
    fr_hi_word[FR_EN_BIT] = fr_en;
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr == ADDR_W'(bank_base(i) + OFS_RELOAD)) bus_rdata = rel_ext[i];
      if (bus_addr == ADDR_W'(bank_base(i) + OFS_COUNT))  bus_rdata = cnt_ext[i];
      if (bus_addr == ADDR_W'(bank_base(i) + OFS_CTRL))   bus_rdata = ctl_ext[i];
    end
    if (bus_addr == ADDR_W'(FR_LO_ADDR)) bus_rdata = fr_cnt[DATA_W-1:0];
    if (bus_addr == ADDR_W'(FR_HI_ADDR)) bus_rdata = fr_hi_word;
  end
endmodule

// File: rtl/cdt_checker.sv
module cdt_checker #(
  parameter int NCH = 3,
  parameter int FR_W = 40
) (
  input logic            clk,
  input logic            rst,
  input logic [NCH-1:0]  irq,
  input logic [NCH-1:0]  uf_evt,
  input logic [NCH-1:0]  clr_evt,
  input logic            fr_en,
  input logic            tick_fr,
  input logic [FR_W-1:0] fr_cnt
);
  for (genvar i = 0; i < NCH; i++) begin : g_irq
    assert_irq_set_R5: assert property (@(posedge clk) disable iff (rst)
      uf_evt[i] |=> irq[i]);
    assert_irq_sticky_R5: assert property (@(posedge clk) disable iff (rst)
      (irq[i] && !clr_evt[i]) |=> irq[i]);
    assert_irq_cleared_R5: assert property (@(posedge clk) disable iff (rst)
      (clr_evt[i] && !uf_evt[i]) |=> !irq[i]);
    assert_irq_source_R4: assert property (@(posedge clk) disable iff (rst)
      $rose(irq[i]) |-> $past(uf_evt[i]));
  end

  assert_fr_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !fr_en |=> $stable(fr_cnt));
  assert_fr_step_R6: assert property (@(posedge clk) disable iff (rst)
    (fr_en && tick_fr) |=> (fr_cnt == $past(fr_cnt) + 1'b1));
endmodule

bind cdt_unit cdt_checker #(.NCH(3), .FR_W(FR_W)) u_chk (
  .clk(clk),
  .rst(rst),
  .irq(irq),
  .uf_evt(uf_evt),
  .clr_evt(clr_evt),
  .fr_en(fr_en),
  .tick_fr(tick_fr),
  .fr_cnt(fr_cnt)
);

// File: tb/sim_cdt_unit.sv
module sim_cdt_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_main = 1'b0, tick_alt = 1'b0, tick_fr = 1'b0;
  logic [2:0]  irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [31:0] m_cnt [3];
  logic [31:0] m_rel [3];
  logic [31:0] m_ctl [3];
  logic        m_irq [3];
  logic [39:0] m_fr;
  logic        m_fren;

  cdt_unit u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_main(tick_main),
    .tick_alt(tick_alt), .tick_fr(tick_fr), .irq(irq)
  );

  always #4 clk = ~clk;

  function automatic logic [7:0] tb_base(input int i);
    return (i == 0) ? 8'h00 : (i == 1) ? 8'h20 : 8'h80;
  endfunction

  function automatic logic [31:0] wmask(input int i);
    return (i == 2) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction

  function automatic logic [7:0] addr_pick(input int k);
    if (k < 12) return tb_base(k / 4) + 8'(4 * (k % 4));
    if (k == 12) return 8'h60;
    if (k == 13) return 8'h64;
    if (k == 14) return 8'h10;
    if (k == 15) return 8'h44;
    return 8'hFC;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    for (int i = 0; i < 3; i++) begin
      if (a == tb_base(i))         return m_rel[i];
      if (a == tb_base(i) + 8'h04) return m_cnt[i];
      if (a == tb_base(i) + 8'h08) return m_ctl[i];
    end
    if (a == 8'h60) return m_fr[31:0];
    if (a == 8'h64) return {23'b0, m_fren, m_fr[39:32]};
    return 32'h0;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 3; i++) begin
      m_cnt[i] = '0; m_rel[i] = '0; m_ctl[i] = '0; m_irq[i] = 1'b0;
    end
    m_fr = '0; m_fren = 1'b0;
  endtask

  task automatic model_step(input bit w, input logic [7:0] a, input logic [31:0] d,
                            input bit tm, input bit ta, input bit tf);
    for (int i = 0; i < 3; i++) begin
      bit en = m_ctl[i][7];
      bit per = m_ctl[i][6];
      bit tk = m_ctl[i][3] ? tm : ta;
      bit uf = 1'b0;
      if (w && a == tb_base(i)) begin
        m_rel[i] = d & wmask(i);
        m_cnt[i] = d & wmask(i);
      end else if (en && tk) begin
        if (m_cnt[i] == 0) begin
          uf = 1'b1;
          m_cnt[i] = per ? m_rel[i] : wmask(i);
        end else m_cnt[i] = m_cnt[i] - 1;
      end
      if (w && a == tb_base(i) + 8'h08) m_ctl[i] = d & 32'h0000_00C8;
      if (uf) m_irq[i] = 1'b1;
      else if (w && a == tb_base(i) + 8'h0C) m_irq[i] = 1'b0;
    end
    if (m_fren && tf) m_fr = m_fr + 40'd1;
    if (w && a == 8'h64) m_fren = d[8];
  endtask

  task automatic cyc(input bit w, input logic [7:0] a, input logic [31:0] d,
                     input bit tm, input bit ta, input bit tf);
    bus_wr = w; bus_addr = a; bus_wdata = d;
    tick_main = tm; tick_alt = ta; tick_fr = tf;
    model_step(w, a, d, tm, ta, tf);
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; tick_main = 1'b0; tick_alt = 1'b0; tick_fr = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    model_reset();
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic chk_all(input string tag);
    for (int k = 0; k < 17; k++) rd_chk(tag, addr_pick(k), exp_rd(addr_pick(k)));
    chk({tag, " irq"}, {29'b0, irq}, {29'b0, m_irq[2], m_irq[1], m_irq[0]});
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    @(negedge clk);
    do_reset();
    chk_all("R8 reset state");

    // R9 control readback, R1 bank layout
    cyc(1, 8'h08, 32'hFFFF_FF7F, 0, 0, 0);
    rd_chk("R9 ctrl bits", 8'h08, 32'h0000_0048);
    cyc(1, 8'h00, 32'h0001_0005, 0, 0, 0);
    rd_chk("R2 count masked to width", 8'h04, 32'h0000_0005);
    rd_chk("R1 clear reads zero", 8'h0C, 32'h0);
    cyc(1, 8'h08, 32'h0000_00C8, 0, 0, 0);
    cyc(0, 8'h00, 0, 0, 1, 0);
    rd_chk("R3 other strobe ignored", 8'h04, 32'd5);
    for (int n = 0; n < 6; n++) cyc(0, 8'h00, 0, 1, 0, 0);
    rd_chk("R4 periodic reload", 8'h04, 32'd5);
    chk("R5 irq after underflow", {31'b0, irq[0]}, 32'd1);
    chk_all("R4 model");
    for (int n = 0; n < 5; n++) cyc(0, 8'h00, 0, 1, 0, 0);
    cyc(1, 8'h0C, 32'h1234_5678, 1, 0, 0);
    chk("R5 underflow beats clear", {31'b0, irq[0]}, 32'd1);
    cyc(1, 8'h0C, 32'h0000_DEAD, 0, 0, 0);
    chk("R5 clear any data", {31'b0, irq[0]}, 32'd0);
    cyc(1, 8'h00, 32'h33, 1, 0, 0);
    rd_chk("R10 reload beats tick", 8'h04, 32'h33);

    // R4 free-running wrap on channel 1 via alternate strobe (R3 select=0)
    cyc(1, 8'h28, 32'h0000_0080, 0, 0, 0);
    cyc(1, 8'h20, 32'h0, 0, 0, 0);
    cyc(0, 8'h00, 0, 1, 0, 0);
    rd_chk("R3 main ignored when select 0", 8'h24, 32'h0);
    cyc(0, 8'h00, 0, 0, 1, 0);
    rd_chk("R4 wrap to all ones", 8'h24, 32'h0000_FFFF);
    cyc(1, 8'h28, 32'h0, 0, 1, 0);
    cyc(0, 8'h00, 0, 0, 1, 0);
    rd_chk("R3 disabled holds", 8'h24, 32'h0000_FFFE);

    // R6 / R7 up-counter
    cyc(1, 8'h64, 32'h0000_0100, 0, 0, 1);
    for (int n = 0; n < 10; n++) cyc(0, 8'h00, 0, 0, 0, 1);
    rd_chk("R6 counts", 8'h60, 32'd10);
    rd_chk("R7 high word", 8'h64, 32'h0000_0100);
    cyc(1, 8'h60, 32'hFFFF_FFFF, 0, 0, 0);
    rd_chk("R6 low write ignored", 8'h60, 32'd10);
    cyc(1, 8'h64, 32'h0, 0, 0, 0);
    cyc(0, 8'h00, 0, 0, 0, 1);
    rd_chk("R6 disabled holds", 8'h60, 32'd10);
    chk_all("R7 model");

    // constrained random phase
    for (int n = 0; n < 3000; n++) begin
      bit w = ($urandom % 10) < 3;
      logic [7:0] a = addr_pick(int'($urandom % 17));
      logic [31:0] d = $urandom;
      if ($urandom % 2) d = d & 32'h0000_013F;
      if ($urandom % 3 == 0) d = d | 32'h0000_0180;
      cyc(w, a, d, ($urandom % 3) == 0, ($urandom % 5) == 0, ($urandom % 2) == 0);
      if (n % 50 == 49) chk_all("R1 R2 R3 R4 R5 random");
      if (n == 1500) begin
        do_reset();
        chk_all("R8 reset mid-run");
      end
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule